// File: doc/BRIEF.md
# TDC Hit Coarse-Time Capture Unit

This block records the timing of one pixel hit for a time-to-digital converter channel. The leading and trailing edges of the discriminator output arrive as asynchronous pulses. A flip-flop synchronizer brings each one into the clock domain, and an edge detector turns it into a single-cycle strobe. On the synchronized leading strobe, the block stores a free-running coarse clock count. It then counts clock cycles until the synchronized trailing strobe, and keeps that count as the time-over-threshold.

The fine interpolation codes, the pixel address and a pile-up flag pass through two register stages. The arbiter's load strobe fills the first stage. The synchronized trailing strobe copies the first stage to the second, which drives the outputs. One cycle after the outputs settle, the block writes the hit to a downstream FIFO, but only if that FIFO was ready when the trailing strobe fired. Otherwise the hit is dropped and a saturating missed-hit counter increments.

The two edge paths clear differently. The load strobe clears the leading synchronizer. The trailing synchronizer relies on the bounded width of its input pulse and is cleared only by the block reset.

Top module: `tdc_hit_capture`

## Requirements
- R1: A rise on `lead_in` produces a one-cycle internal leading strobe on the third rising clock edge after the rise. On that edge `hit_coarse` loads the `coarse_cnt` value present at that edge.
- R2: A clock edge with `par_load` high loads the first stage with `lead_fine`, `trail_fine`, `pix_addr` and `pileup`. The hit outputs keep their previous values until the next trailing strobe.
- R3: A rise on `trail_in` produces a one-cycle trailing strobe on the third rising edge after the rise. On that edge `hit_lead_fine`, `hit_trail_fine`, `hit_addr` and `hit_pileup` take the first-stage contents.
- R4: An edge with `par_load` high clears the leading synchronizer. A `lead_in` pulse still in flight there is discarded, and `hit_coarse` stays unchanged.
- R5: `par_load` has no effect on the trailing synchronizer. A load strobe during a trailing rise still lets the trailing strobe and the FIFO write happen on schedule.
- R6: `hit_tot` equals the number of clock edges from the leading strobe to the trailing strobe. It saturates at 2^TOT_W-1, which is 15 by default.
- R7: When the leading and trailing strobes fire on the same clock edge, `hit_tot` is 0.
- R8: `fifo_wr` is high for exactly one cycle. That cycle lies between the fourth and fifth rising edges after the `trail_in` rise, one cycle after the outputs update. It occurs only when `fifo_ready` was high on the trailing-strobe edge.
- R9: `missed_cnt` increments by one when `fifo_ready` is low on the trailing-strobe edge. It holds at 2^MISS_W-1, and the synchronous reset clears it to 0.
- R10: While `rst` is high at a clock edge, every output register is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lead_in | input | 1 | Asynchronous leading-edge pulse |
| trail_in | input | 1 | Asynchronous trailing-edge pulse of bounded width |
| par_load | input | 1 | Arbiter load strobe for the first register stage |
| coarse_cnt | input | COARSE_W | Free-running coarse clock count |
| lead_fine | input | FINE_W | Leading fine interpolation code |
| trail_fine | input | FINE_W | Trailing fine interpolation code |
| pix_addr | input | ADDR_W | Pixel address |
| pileup | input | 1 | Pile-up flag |
| fifo_ready | input | 1 | Downstream FIFO can accept a hit |
| hit_coarse | output | COARSE_W | Captured coarse timestamp |
| hit_lead_fine | output | FINE_W | Second-stage leading fine code |
| hit_trail_fine | output | FINE_W | Second-stage trailing fine code |
| hit_addr | output | ADDR_W | Second-stage pixel address |
| hit_pileup | output | 1 | Second-stage pile-up flag |
| hit_tot | output | TOT_W | Time-over-threshold in clock cycles |
| fifo_wr | output | 1 | One-cycle FIFO write strobe |
| missed_cnt | output | MISS_W | Saturating count of dropped hits |

## Verification
The assertions take four things for granted about the inputs. At most one hit is in flight at a time. The leading edge rises no later than the trailing edge. `trail_in` falls before the next hit begins. `par_load` does not pulse while `lead_in` is still high, because that would re-arm the leading path and create a second leading strobe. The stimulus changes every input on falling clock edges, in whole-cycle steps. It loads the first stage while both edge inputs are low, then holds each edge input high until the strobe has been taken. The one directed case that pulses `par_load` during a hit lowers `lead_in` first, so this rule still holds.

// File: rtl/tdc_hit_pkg.sv
package tdc_hit_pkg;
   typedef enum logic {
      TOT_IDLE = 1'b0,
      TOT_RUN  = 1'b1
   } tot_state_e;

   localparam int DEF_COARSE_W = 11;
   localparam int DEF_FINE_W   = 5;
   localparam int DEF_ADDR_W   = 5;
   localparam int DEF_TOT_W    = 4;
   localparam int DEF_MISS_W   = 8;
   localparam int DEF_SYNC     = 2;
endpackage

// File: rtl/tdc_edge_sync.sv
module tdc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic din,
   output logic pulse
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   // shift register synchronizer plus one register for edge detection
   always_ff @(posedge clk) begin
      if (rst || clr) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign pulse = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tdc_tot_counter.sv
module tdc_tot_counter
   import tdc_hit_pkg::*;
#(
   parameter int TOT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             stop,
   output logic [TOT_W-1:0] tot
);
   localparam logic [TOT_W-1:0] TOT_MAX = '1;
   localparam logic [TOT_W-1:0] TOT_ONE = TOT_W'(1);

   tot_state_e       state_q;
   logic [TOT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= TOT_IDLE;
         cnt_q   <= '0;
         tot     <= '0;
      end else if (stop) begin
         state_q <= TOT_IDLE;
         // coincident start and stop, or stop without start, yields zero
         tot     <= (start || state_q == TOT_IDLE) ? '0 : cnt_q;
      end else if (start) begin
         state_q <= TOT_RUN;
         cnt_q   <= TOT_ONE;
      end else if (state_q == TOT_RUN && cnt_q != TOT_MAX) begin
         cnt_q   <= cnt_q + TOT_ONE;
      end
   end
endmodule

// File: rtl/tdc_sat_counter.sv
module tdc_sat_counter #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc,
   output logic [WIDTH-1:0] count
);
   localparam logic [WIDTH-1:0] CNT_MAX = '1;

   always_ff @(posedge clk) begin
      if (rst)
         count <= '0;
      else if (inc && count != CNT_MAX)
         count <= count + WIDTH'(1);
   end
endmodule

// File: rtl/tdc_hit_capture.sv
module tdc_hit_capture
   import tdc_hit_pkg::*;
#(
   parameter int COARSE_W    = DEF_COARSE_W,
   parameter int FINE_W      = DEF_FINE_W,
   parameter int ADDR_W      = DEF_ADDR_W,
   parameter int TOT_W       = DEF_TOT_W,
   parameter int MISS_W      = DEF_MISS_W,
   parameter int SYNC_STAGES = DEF_SYNC
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                lead_in,
   input  logic                trail_in,
   input  logic                par_load,
   input  logic [COARSE_W-1:0] coarse_cnt,
   input  logic [FINE_W-1:0]   lead_fine,
   input  logic [FINE_W-1:0]   trail_fine,
   input  logic [ADDR_W-1:0]   pix_addr,
   input  logic                pileup,
   input  logic                fifo_ready,
   output logic [COARSE_W-1:0] hit_coarse,
   output logic [FINE_W-1:0]   hit_lead_fine,
   output logic [FINE_W-1:0]   hit_trail_fine,
   output logic [ADDR_W-1:0]   hit_addr,
   output logic                hit_pileup,
   output logic [TOT_W-1:0]    hit_tot,
   output logic                fifo_wr,
   output logic [MISS_W-1:0]   missed_cnt
);
   localparam int STG_W = 2*FINE_W + ADDR_W + 1;

   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tdc_hit_capture: SYNC_STAGES must be at least 2");
   end
   if (COARSE_W < 1 || FINE_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("tdc_hit_capture: field widths must be positive");
   end
   if (TOT_W < 2 || MISS_W < 1) begin : g_bad_cnt
      $error("tdc_hit_capture: counter widths too small");
   end

   logic             lead_pulse;
   logic             trail_pulse;
   logic [STG_W-1:0] stage1_q;
   logic [STG_W-1:0] stage2_q;
   logic             wr_pend_q;

   // leading path: cleared by the arbiter load strobe
   tdc_edge_sync #(.STAGES(SYNC_STAGES)) u_lead_sync (
      .clk   (clk),
      .rst   (rst),
      .clr   (par_load),
      .din   (lead_in),
      .pulse (lead_pulse)
   );

   // trailing path: bounded input width, cleared only by reset
   tdc_edge_sync #(.STAGES(SYNC_STAGES)) u_trail_sync (
      .clk   (clk),
      .rst   (rst),
      .clr   (1'b0),
      .din   (trail_in),
      .pulse (trail_pulse)
   );

   always_ff @(posedge clk) begin
      if (rst)
         hit_coarse <= '0;
      else if (lead_pulse)
         hit_coarse <= coarse_cnt;
   end

   always_ff @(posedge clk) begin
      if (rst)
         stage1_q <= '0;
      else if (par_load)
         stage1_q <= {lead_fine, trail_fine, pix_addr, pileup};
   end

   always_ff @(posedge clk) begin
      if (rst)
         stage2_q <= '0;
      else if (trail_pulse)
         stage2_q <= stage1_q;
   end

   assign {hit_lead_fine, hit_trail_fine, hit_addr, hit_pileup} = stage2_q;

   tdc_tot_counter #(.TOT_W(TOT_W)) u_tot (
      .clk   (clk),
      .rst   (rst),
      .start (lead_pulse),
      .stop  (trail_pulse),
      .tot   (hit_tot)
   );

   // write is requested on the strobe edge and issued one cycle later
   always_ff @(posedge clk) begin
      if (rst) begin
         wr_pend_q <= 1'b0;
         fifo_wr   <= 1'b0;
      end else begin
         wr_pend_q <= trail_pulse & fifo_ready;
         fifo_wr   <= wr_pend_q;
      end
   end

   tdc_sat_counter #(.WIDTH(MISS_W)) u_missed (
      .clk   (clk),
      .rst   (rst),
      .inc   (trail_pulse & ~fifo_ready),
      .count (missed_cnt)
   );
endmodule

// File: rtl/tdc_hit_capture_chk.sv
module tdc_hit_capture_chk #(
   parameter int COARSE_W = 11,
   parameter int FINE_W   = 5,
   parameter int ADDR_W   = 5,
   parameter int TOT_W    = 4,
   parameter int MISS_W   = 8
) (
   input logic                           clk,
   input logic                           rst,
   input logic                           par_load,
   input logic                           fifo_ready,
   input logic [COARSE_W-1:0]            coarse_cnt,
   input logic                           lead_pulse,
   input logic                           trail_pulse,
   input logic [2*FINE_W+ADDR_W:0]       stage1_q,
   input logic [COARSE_W-1:0]            hit_coarse,
   input logic [FINE_W-1:0]              hit_lead_fine,
   input logic [FINE_W-1:0]              hit_trail_fine,
   input logic [ADDR_W-1:0]              hit_addr,
   input logic                           hit_pileup,
   input logic [TOT_W-1:0]               hit_tot,
   input logic                           fifo_wr,
   input logic [MISS_W-1:0]              missed_cnt
);
   localparam logic [MISS_W-1:0] MISS_MAX = '1;

   a_r1_coarse_load: assert property (@(posedge clk) disable iff (rst)
      lead_pulse |=> hit_coarse == $past(coarse_cnt));

   a_r1_lead_single: assert property (@(posedge clk) disable iff (rst)
      lead_pulse |=> !lead_pulse);

   a_r2_outputs_hold: assert property (@(posedge clk) disable iff (rst)
      !trail_pulse |=> $stable({hit_lead_fine, hit_trail_fine, hit_addr, hit_pileup}));

   a_r3_stage_copy: assert property (@(posedge clk) disable iff (rst)
      trail_pulse |=> {hit_lead_fine, hit_trail_fine, hit_addr, hit_pileup} == $past(stage1_q));

   a_r4_load_clears_lead: assert property (@(posedge clk) disable iff (rst)
      par_load |=> !lead_pulse);

   a_r7_same_edge_zero: assert property (@(posedge clk) disable iff (rst)
      (lead_pulse && trail_pulse) |=> hit_tot == '0);

   a_r8_wr_single: assert property (@(posedge clk) disable iff (rst)
      fifo_wr |=> !fifo_wr);

   a_r8_wr_cause: assert property (@(posedge clk) disable iff (rst)
      fifo_wr |-> ($past(trail_pulse, 2) && $past(fifo_ready, 2)));

   a_r9_miss_inc: assert property (@(posedge clk) disable iff (rst)
      (trail_pulse && !fifo_ready && missed_cnt != MISS_MAX)
         |=> missed_cnt == MISS_W'($past(missed_cnt) + 1'b1));

   a_r9_miss_sat: assert property (@(posedge clk) disable iff (rst)
      (trail_pulse && !fifo_ready && missed_cnt == MISS_MAX) |=> missed_cnt == MISS_MAX);

   a_r9_miss_hold: assert property (@(posedge clk) disable iff (rst)
      !(trail_pulse && !fifo_ready) |=> $stable(missed_cnt));
endmodule

bind tdc_hit_capture tdc_hit_capture_chk #(
   .COARSE_W (COARSE_W),
   .FINE_W   (FINE_W),
   .ADDR_W   (ADDR_W),
   .TOT_W    (TOT_W),
   .MISS_W   (MISS_W)
) u_chk (
   .clk            (clk),
   .rst            (rst),
   .par_load       (par_load),
   .fifo_ready     (fifo_ready),
   .coarse_cnt     (coarse_cnt),
   .lead_pulse     (lead_pulse),
   .trail_pulse    (trail_pulse),
   .stage1_q       (stage1_q),
   .hit_coarse     (hit_coarse),
   .hit_lead_fine  (hit_lead_fine),
   .hit_trail_fine (hit_trail_fine),
   .hit_addr       (hit_addr),
   .hit_pileup     (hit_pileup),
   .hit_tot        (hit_tot),
   .fifo_wr        (fifo_wr),
   .missed_cnt     (missed_cnt)
);

// File: tb/tdc_hit_capture_bench.sv
module tdc_hit_capture_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 11;
   localparam int FW = 5;
   localparam int AW = 5;
   localparam int TW = 4;
   localparam int MW = 3;
   localparam int TOT_CAP  = (1 << TW) - 1;
   localparam int MISS_CAP = (1 << MW) - 1;
   localparam int NVEC = 6;

   // {tot_gap[4:0], ready, lead_fine, trail_fine, addr, pileup}
   localparam logic [21:0] VEC [NVEC] = '{
      {5'd3,  1'b1, 5'h01, 5'h1E, 5'h0A, 1'b0},
      {5'd0,  1'b1, 5'h1F, 5'h00, 5'h15, 1'b1},
      {5'd1,  1'b0, 5'h07, 5'h08, 5'h1F, 1'b0},
      {5'd15, 1'b1, 5'h10, 5'h03, 5'h00, 1'b1},
      {5'd20, 1'b1, 5'h0C, 5'h11, 5'h05, 1'b0},
      {5'd7,  1'b0, 5'h02, 5'h1C, 5'h13, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          lead_in = 1'b0;
   logic          trail_in = 1'b0;
   logic          par_load = 1'b0;
   logic [CW-1:0] coarse_cnt = '0;
   logic [FW-1:0] lead_fine = '0;
   logic [FW-1:0] trail_fine = '0;
   logic [AW-1:0] pix_addr = '0;
   logic          pileup = 1'b0;
   logic          fifo_ready = 1'b0;
   logic [CW-1:0] hit_coarse;
   logic [FW-1:0] hit_lead_fine;
   logic [FW-1:0] hit_trail_fine;
   logic [AW-1:0] hit_addr;
   logic          hit_pileup;
   logic [TW-1:0] hit_tot;
   logic          fifo_wr;
   logic [MW-1:0] missed_cnt;

   int  n_checks = 0;
   int  n_fail = 0;
   int  exp_miss = 0;
   logic [15:0] exp_fields = '0;
   bit  done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tdc_hit_capture #(
      .COARSE_W(CW), .FINE_W(FW), .ADDR_W(AW), .TOT_W(TW), .MISS_W(MW), .SYNC_STAGES(2)
   ) u_tdc_hit_capture (
      .clk, .rst, .lead_in, .trail_in, .par_load, .coarse_cnt, .lead_fine,
      .trail_fine, .pix_addr, .pileup, .fifo_ready, .hit_coarse, .hit_lead_fine,
      .hit_trail_fine, .hit_addr, .hit_pileup, .hit_tot, .fifo_wr, .missed_cnt
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // advance to the next falling edge; the coarse count free-runs there
   task automatic tick();
      @(negedge clk);
      coarse_cnt = coarse_cnt + 1'b1;
   endtask

   task automatic run_hit(input logic [21:0] v);
      int gap;
      logic rdy;
      logic [CW-1:0] c0;
      gap = int'(v[21:17]);
      rdy = v[16];
      tick();
      {lead_fine, trail_fine, pix_addr, pileup} = v[15:0];
      fifo_ready = rdy;
      par_load = 1'b1;
      tick();
      par_load = 1'b0;
      check("R2 outputs held after load", 32'({hit_lead_fine, hit_trail_fine, hit_addr, hit_pileup}),
            32'(exp_fields));
      lead_in = 1'b1;
      c0 = coarse_cnt;
      if (gap == 0) trail_in = 1'b1;
      for (int k = 1; k <= gap; k++) begin
         tick();
         if (k == gap) trail_in = 1'b1;
      end
      tick(); tick(); tick();
      exp_fields = v[15:0];
      check("R3 second stage fields", 32'({hit_lead_fine, hit_trail_fine, hit_addr, hit_pileup}),
            32'(exp_fields));
      check("R1 coarse timestamp", 32'(hit_coarse), 32'(CW'(c0 + 2)));
      if (gap == 0)
         check("R7 same-edge tot", 32'(hit_tot), 32'd0);
      else
         check("R6 tot cycles", 32'(hit_tot), 32'((gap > TOT_CAP) ? TOT_CAP : gap));
      check("R8 no write before slot", 32'(fifo_wr), 32'd0);
      if (!rdy && exp_miss < MISS_CAP) exp_miss++;
      tick();
      check("R8 write slot", 32'(fifo_wr), 32'(rdy));
      check("R9 missed count", 32'(missed_cnt), 32'(exp_miss));
      tick();
      check("R8 write one cycle", 32'(fifo_wr), 32'd0);
      lead_in = 1'b0;
      trail_in = 1'b0;
      repeat (4) tick();
   endtask

   initial begin : wd
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [CW-1:0] held;
      repeat (3) tick();
      // R10: reset state
      check("R10 reset coarse", 32'(hit_coarse), 32'd0);
      check("R10 reset fields", 32'({hit_lead_fine, hit_trail_fine, hit_addr, hit_pileup}), 32'd0);
      check("R10 reset tot", 32'(hit_tot), 32'd0);
      check("R10 reset wr", 32'(fifo_wr), 32'd0);
      check("R10 reset missed", 32'(missed_cnt), 32'd0);
      rst = 1'b0;
      repeat (2) tick();

      for (int i = 0; i < NVEC; i++) run_hit(VEC[i]);

      // R4: load strobe discards a leading pulse in flight
      held = hit_coarse;
      lead_in = 1'b1;
      tick();
      lead_in = 1'b0;
      par_load = 1'b1;
      tick();
      par_load = 1'b0;
      repeat (4) tick();
      check("R4 coarse unchanged after clear", 32'(hit_coarse), 32'(held));

      // R5: load strobe during a trailing rise does not disturb it
      {lead_fine, trail_fine, pix_addr, pileup} = 16'h5A5A;
      fifo_ready = 1'b1;
      par_load = 1'b1;
      tick();
      par_load = 1'b0;
      lead_in = 1'b1;
      repeat (4) tick();
      lead_in = 1'b0;
      trail_in = 1'b1;
      tick();
      par_load = 1'b1;
      tick();
      par_load = 1'b0;
      tick();
      tick();
      check("R5 write despite load", 32'(fifo_wr), 32'd1);
      check("R5 tot kept", 32'(hit_tot), 32'd4);
      check("R5 fields", 32'({hit_lead_fine, hit_trail_fine, hit_addr, hit_pileup}), 32'h5A5A);
      exp_fields = 16'h5A5A;
      trail_in = 1'b0;
      repeat (4) tick();

      // R9: saturation of the missed counter
      for (int j = 0; j < 8; j++) run_hit({5'd2, 1'b0, 5'h03, 5'h04, 5'(j), 1'b0});
      check("R9 missed saturated", 32'(missed_cnt), 32'(MISS_CAP));

      // R9: reset clears the counter
      tick();
      rst = 1'b1;
      tick();
      rst = 1'b0;
      tick();
      check("R9 missed cleared by reset", 32'(missed_cnt), 32'd0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule